// File: doc/BRIEF.md
# Vectored Interrupt Controller with Parity-Protected Vector Table

The block collects a wide set of level-sensitive interrupt request lines and reduces them to a single winning interrupt for the processor. Each request line passes through its own enable bit. A programmable map then places request lines onto priority slots. The lowest-numbered slot whose line is pending and enabled wins. One register stage holds the winner, so a request seen at a clock edge is visible at the dispatch outputs during the next cycle.

The winner is offered in three ways, all at the same time. A hardware port carries a valid flag, the handler address and an acknowledge input. An index register returns the winning slot number plus one. A vector-address register returns the winner's handler address. Handler addresses live in an internal table indexed by slot. Each entry stores an even-parity bit, and that bit is checked whenever the dispatch logic reads the entry. On a mismatch the block substitutes a programmable fallback address, sets a sticky error flag and records the failing slot. A plain register bus with a one-cycle read latency configures the block. A separate write window stores entries with a deliberately wrong parity bit, so the error path can be exercised.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The winner is the lowest priority slot p whose mapped request line is high and enabled. The index register (control offset 0x00) reads p+1, and reads 0 when nothing is pending.
- R2: Enable words sit at control offset 0x10+w. Bit b of word w enables request line w*DATA_W+b. A disabled line never wins.
- R3: Priority-map entry p (address region 1, offset p) names the request line that feeds slot p. After reset, slot p is fed by line p.
- R4: Slot 0 is always fed by line 0, and line 0 is always enabled. Writes to map entry 0 and to enable bit 0 have no effect, and both read back as their fixed values.
- R5: A request that is high at a clock edge drives `hw_valid` high in the following cycle. In that cycle `hw_vector` carries the winning slot's handler address.
- R6: After a clock edge at which `hw_valid` and `hw_ack` are both high, `hw_valid` is low for exactly one cycle. After that cycle the winner is evaluated again.
- R7: The vector-address register (control offset 0x01) returns the winning slot's handler address. It and `hw_vector` read 0 when nothing is pending.
- R8: A write to region 2, offset p, stores a handler address with an even-parity bit (the XOR of the data bits). A write to region 3, offset p, stores the same data with that parity bit inverted. Reads of either region return the stored data.
- R9: When the winning entry fails its parity check, the fallback address (control offset 0x02) replaces the handler address on `hw_vector` and in the vector-address register.
- R10: A parity failure sets a sticky error flag, which is bit 0 of control offset 0x03 and also appears on `par_err`. The same event records the slot in bits [CH_W:1]. Writing 1 to bit 0 clears the flag, unless a failure occurs in the same cycle.
- R11: A read returns data on `bus_rdata` in the cycle after `bus_rd`. After reset nothing is pending, only line 0 is enabled, and the fallback, the error register and all table entries are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_CH | Level interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Register address; bits [9:8] select the region |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle after `bus_rd` |
| hw_valid | output | 1 | Hardware dispatch: a winner is present |
| hw_vector | output | DATA_W | Hardware dispatch: handler address |
| hw_ack | input | 1 | Hardware dispatch acknowledge |
| par_err | output | 1 | Sticky vector-table parity error flag |

## Verification
The bench builds the block with 8 request lines and 16-bit data. This makes all 256 request patterns cheap to sweep twice: once with the identity map and all lines enabled, and once with a reversed map and two lines masked. In each sweep the bench compares the hardware port, the index register and the vector-address register against a winner it computes arithmetically. The small width also keeps the error register's slot field and the enable word in a single 16-bit read. That lets the bench check the fixed slot-0 behaviour, the acknowledge gap, and a fault injected into one table entry, together with its fallback and its clearing.

// File: rtl/irq_pkg.sv
// Shared constants and types for the vectored interrupt controller.
// Assumes a 10-bit word address whose top two bits select a region.
package irq_pkg;
    localparam int ADDR_W = 10;

    typedef enum logic [1:0] {
        RGN_CTRL = 2'd0,   // control and status registers
        RGN_PRIO = 2'd1,   // priority slot -> request line map
        RGN_VEC  = 2'd2,   // vector table, normal parity
        RGN_VINJ = 2'd3    // vector table, inverted parity on write
    } region_e;

    localparam logic [7:0] REG_INDEX    = 8'h00;
    localparam logic [7:0] REG_VADDR    = 8'h01;
    localparam logic [7:0] REG_FALLBACK = 8'h02;
    localparam logic [7:0] REG_ERR      = 8'h03;
    localparam logic [7:0] REG_EN_BASE  = 8'h10;
endpackage

// File: rtl/irq_prio_map.sv
// Maps request lines onto priority slots and masks them with line enables.
// Assumes the map entries are always in range (CH_W bits index NUM_CH lines).
module irq_prio_map #(
    parameter int NUM_CH = 128,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] irq_req,
    input  logic [NUM_CH-1:0] line_en,
    input  logic [CH_W-1:0]   slot_src [NUM_CH],
    output logic [NUM_CH-1:0] slot_pend
);
    // One selector per slot: the pending state of the line feeding that slot.
    for (genvar p = 0; p < NUM_CH; p++) begin : g_slot
        assign slot_pend[p] = irq_req[slot_src[p]] & line_en[slot_src[p]];
    end
endmodule

// File: rtl/irq_arbiter.sv
// Fixed-priority arbiter: the lowest pending slot wins; the result is registered.
// Assumes slot numbers are unique, so no tie can arise.
module irq_arbiter #(
    parameter int NUM_CH = 128,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] slot_pend,
    output logic              win_valid,
    output logic [CH_W-1:0]   win_slot
);
    logic            any_c;
    logic [CH_W-1:0] idx_c;

    // Scan from the top down so the lowest pending slot is the last to write.
    always_comb begin
        any_c = 1'b0;
        idx_c = '0;
        for (int p = NUM_CH - 1; p >= 0; p--) begin
            if (slot_pend[p]) begin
                any_c = 1'b1;
                idx_c = CH_W'(p);
            end
        end
    end

    // Hold the winner for one cycle to cut the path to table and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_slot  <= '0;
        end else begin
            win_valid <= any_c;
            win_slot  <= idx_c;
        end
    end
endmodule

// File: rtl/irq_vec_table.sv
// Handler-address table with one even-parity bit per entry.
// Port A is the dispatch read (parity checked); port B serves bus reads.
// Assumes a single write per cycle; flip inverts the stored parity bit.
module irq_vec_table #(
    parameter int NUM_CH = 128,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_flip,
    input  logic [CH_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_bad,
    input  logic [CH_W-1:0]   rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data
);
    logic [DATA_W:0] mem [NUM_CH];
    logic [DATA_W:0] ent_a;

    // Store data with its parity bit; clear every entry on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_CH; p++) mem[p] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= {(^wr_data) ^ wr_flip, wr_data};
        end
    end

    // Dispatch read with parity check.
    assign ent_a     = mem[rd_a_idx];
    assign rd_a_data = ent_a[DATA_W-1:0];
    assign rd_a_bad  = ent_a[DATA_W] != (^ent_a[DATA_W-1:0]);

    // Bus read returns the data only.
    logic [DATA_W:0] ent_b;
    assign ent_b     = mem[rd_b_idx];
    assign rd_b_data = ent_b[DATA_W-1:0];
endmodule

// File: rtl/irq_vector_ctrl.sv
// Vectored interrupt controller top: register bus, enables, priority map,
// arbitration, vector lookup with parity fallback, and three dispatch paths.
// Assumes DATA_W > CH_W + 1 so the error register fits in one word.
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_CH = 128,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_req,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              hw_valid,
    output logic [DATA_W-1:0] hw_vector,
    input  logic              hw_ack,
    output logic              par_err
);
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int EN_WORDS = (NUM_CH + DATA_W - 1) / DATA_W;

    region_e           region;
    logic [7:0]        off;
    logic              off_in_ch;
    int                en_sel;
    logic              en_hit;

    logic [NUM_CH-1:0] en_q;
    logic [CH_W-1:0]   map_q [NUM_CH];
    logic [DATA_W-1:0] fallback_q;
    logic              err_q;
    logic [CH_W-1:0]   err_slot_q;
    logic              blank_q;

    logic [NUM_CH-1:0] slot_pend;
    logic              win_valid;
    logic [CH_W-1:0]   win_slot;
    logic [DATA_W-1:0] tbl_a_data;
    logic              tbl_a_bad;
    logic [DATA_W-1:0] tbl_b_data;
    logic              tbl_wr;
    logic [DATA_W-1:0] resolved;
    logic [CH_W:0]     idx_plus;
    logic [DATA_W-1:0] en_rd_word;
    logic [DATA_W-1:0] rd_val;
    logic              err_clr;

    // Address decode.
    assign region    = region_e'(bus_addr[ADDR_W-1:ADDR_W-2]);
    assign off       = bus_addr[7:0];
    assign off_in_ch = int'(off) < NUM_CH;
    assign en_sel    = int'(off) - int'(REG_EN_BASE);
    assign en_hit    = (region == RGN_CTRL) && (en_sel >= 0) && (en_sel < EN_WORDS);
    assign tbl_wr    = bus_wr && off_in_ch && (region == RGN_VEC || region == RGN_VINJ);
    assign err_clr   = bus_wr && region == RGN_CTRL && off == REG_ERR && bus_wdata[0];

    // Line enables; line 0 is forced on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= NUM_CH'(1);
        end else if (bus_wr && en_hit) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (i / DATA_W == en_sel) en_q[i] <= (i == 0) ? 1'b1 : bus_wdata[i % DATA_W];
            end
        end
    end

    // Priority map; slot 0 stays tied to line 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_CH; p++) map_q[p] <= CH_W'(p);
        end else if (bus_wr && region == RGN_PRIO && off_in_ch && off[CH_W-1:0] != '0) begin
            map_q[off[CH_W-1:0]] <= bus_wdata[CH_W-1:0];
        end
    end

    // Fallback vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) fallback_q <= '0;
        else if (bus_wr && region == RGN_CTRL && off == REG_FALLBACK) fallback_q <= bus_wdata;
    end

    irq_prio_map #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_map (
        .irq_req   (irq_req),
        .line_en   (en_q),
        .slot_src  (map_q),
        .slot_pend (slot_pend)
    );

    irq_arbiter #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_pend (slot_pend),
        .win_valid (win_valid),
        .win_slot  (win_slot)
    );

    irq_vec_table #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_wr),
        .wr_flip   (region == RGN_VINJ),
        .wr_idx    (off[CH_W-1:0]),
        .wr_data   (bus_wdata),
        .rd_a_idx  (win_slot),
        .rd_a_data (tbl_a_data),
        .rd_a_bad  (tbl_a_bad),
        .rd_b_idx  (off[CH_W-1:0]),
        .rd_b_data (tbl_b_data)
    );

    // Winner address, with fallback on a parity failure.
    assign resolved = !win_valid ? '0 : (tbl_a_bad ? fallback_q : tbl_a_data);
    assign idx_plus = {1'b0, win_slot} + (CH_W + 1)'(1);

    // Sticky parity error and failing slot; a failure beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q      <= 1'b0;
            err_slot_q <= '0;
        end else if (win_valid && tbl_a_bad) begin
            err_q      <= 1'b1;
            err_slot_q <= win_slot;
        end else if (err_clr) begin
            err_q      <= 1'b0;
        end
    end

    // One-cycle gap in hw_valid after an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) blank_q <= 1'b0;
        else        blank_q <= hw_valid && hw_ack;
    end

    assign hw_valid  = win_valid && !blank_q;
    assign hw_vector = resolved;
    assign par_err   = err_q;

    // Gather the selected enable word for reads.
    always_comb begin
        en_rd_word = '0;
        for (int b = 0; b < DATA_W; b++) begin
            if (en_hit && en_sel * DATA_W + b < NUM_CH) en_rd_word[b] = en_q[en_sel * DATA_W + b];
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_val = '0;
        case (region)
            RGN_CTRL: begin
                if (en_hit) rd_val = en_rd_word;
                else begin
                    case (off)
                        REG_INDEX:    rd_val = win_valid ? DATA_W'(idx_plus) : '0;
                        REG_VADDR:    rd_val = resolved;
                        REG_FALLBACK: rd_val = fallback_q;
                        REG_ERR:      rd_val = DATA_W'({err_slot_q, err_q});
                        default:      rd_val = '0;
                    endcase
                end
            end
            RGN_PRIO: if (off_in_ch) rd_val = DATA_W'(map_q[off[CH_W-1:0]]);
            default:  if (off_in_ch) rd_val = tbl_b_data;
        endcase
    end

    // Registered read data, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Property checker for irq_vector_ctrl, attached by bind below.
module irq_vector_ctrl_chk
    import irq_pkg::*;
#(
    parameter int NUM_CH = 128,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] irq_req,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              hw_valid,
    input logic              hw_ack,
    input logic              par_err
);
    logic clr_now;
    assign clr_now = bus_wr && bus_addr == {2'b00, REG_ERR} && bus_wdata[0];

    // R6: an acknowledged dispatch is followed by one cycle without valid.
    p_ack_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_valid && hw_ack |=> !hw_valid);

    // R1: with no request at the previous edge, nothing is offered.
    p_idle_no_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(irq_req) == '0 |-> !hw_valid);

    // R4: line 0 can never be masked away.
    p_line0_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(irq_req[0]) && !$past(hw_valid && hw_ack) |-> hw_valid);

    // R10: the error flag holds until an explicit clear.
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        par_err && !clr_now |=> par_err);

    // R5: valid needs a request at the previous edge.
    p_valid_has_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && hw_valid |-> $past(irq_req) != '0);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hw_valid  (hw_valid),
    .hw_ack    (hw_ack),
    .par_err   (par_err)
);

// File: tb/sim_irq_vector_ctrl.sv
// Sweep bench for irq_vector_ctrl with 8 lines and 16-bit data.
module sim_irq_vector_ctrl;
    localparam int NC = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] irq_req = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          hw_valid;
    logic [DW-1:0] hw_vector;
    logic          hw_ack = 1'b0;
    logic          par_err;

    int n_chk = 0;
    int n_bad = 0;
    int map_m [NC];
    logic [NC-1:0] en_m;

    always #2 clk = ~clk;

    irq_vector_ctrl #(.NUM_CH(NC), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_valid(hw_valid), .hw_vector(hw_vector), .hw_ack(hw_ack),
        .par_err(par_err)
    );

    function automatic logic [DW-1:0] vec_of(input int p);
        return DW'(16'hA000 + p * 17);
    endfunction

    // Winning slot per the requirements, -1 when none.
    function automatic int exp_slot(input logic [NC-1:0] req);
        for (int p = 0; p < NC; p++) begin
            if (req[map_m[p]] && (map_m[p] == 0 || en_m[map_m[p]])) return p;
        end
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [DW-1:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [DW-1:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    // Drive every request pattern and compare all three dispatch paths.
    task automatic sweep(input string tag);
        logic [DW-1:0] rd;
        for (int pat = 0; pat < 256; pat++) begin
            int w;
            @(negedge clk); irq_req = NC'(pat);
            w = exp_slot(NC'(pat));
            @(negedge clk);
            chk({tag, " R5 valid"}, hw_valid, w >= 0);
            chk({tag, " R5 vector"}, hw_vector, w >= 0 ? vec_of(w) : '0);
            bus_read(10'h000, rd);
            chk({tag, " R1 index"}, rd, w >= 0 ? w + 1 : 0);
            bus_read(10'h001, rd);
            chk({tag, " R7 vaddr"}, rd, w >= 0 ? vec_of(w) : '0);
        end
        @(negedge clk); irq_req = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk("R11 valid after reset", hw_valid, 0);
        bus_read(10'h000, rd); chk("R1 index idle", rd, 0);
        bus_read(10'h003, rd); chk("R11 err reset", rd, 0);
        bus_read(10'h102, rd); chk("R3 map reset", rd, 2);
        bus_read(10'h010, rd); chk("R11 enables reset", rd, 1);
        bus_read(10'h205, rd); chk("R11 table reset", rd, 0);

        // R4: slot 0 map is fixed
        bus_write(10'h100, 16'd5);
        bus_read(10'h100, rd); chk("R4 map slot0 fixed", rd, 0);

        // Program table and enables
        for (int p = 0; p < NC; p++) bus_write(10'h200 + 10'(p), vec_of(p));
        bus_read(10'h206, rd); chk("R8 table readback", rd, vec_of(6));
        bus_write(10'h010, 16'h00FF);
        for (int p = 0; p < NC; p++) map_m[p] = p;
        en_m = 8'hFF;
        sweep("identity");

        // R2 R3: reversed map, lines 3 and 6 masked, bit 0 written as 0
        for (int p = 1; p < NC; p++) begin
            bus_write(10'h100 + 10'(p), DW'(NC - p));
            map_m[p] = NC - p;
        end
        bus_write(10'h010, 16'h00B6);
        en_m = 8'hB7;
        bus_read(10'h010, rd); chk("R4 line0 enable forced", rd, 16'h00B7);
        bus_read(10'h101, rd); chk("R3 map readback", rd, 7);
        sweep("reversed R2 R3");

        // R6: acknowledge gap
        @(negedge clk); irq_req = 8'h01;
        @(negedge clk); chk("R6 valid before ack", hw_valid, 1);
        hw_ack = 1'b1;
        @(negedge clk); chk("R6 gap after ack", hw_valid, 0);
        hw_ack = 1'b0;
        @(negedge clk); chk("R6 valid again", hw_valid, 1);
        chk("R6 vector again", hw_vector, vec_of(0));
        irq_req = '0;

        // R9 R10: corrupt slot 3 (fed by line 5)
        bus_write(10'h303, vec_of(3));
        bus_write(10'h002, 16'hDEAD);
        bus_read(10'h303, rd); chk("R8 inject readback", rd, vec_of(3));
        @(negedge clk); irq_req = 8'h20;
        @(negedge clk);
        chk("R9 fallback on port", hw_vector, 16'hDEAD);
        chk("R9 valid on bad entry", hw_valid, 1);
        bus_read(10'h001, rd); chk("R9 fallback vaddr", rd, 16'hDEAD);
        bus_read(10'h003, rd); chk("R10 err reg", rd, 16'h0007);
        chk("R10 par_err pin", par_err, 1);
        @(negedge clk); irq_req = '0;
        @(negedge clk); @(negedge clk);
        chk("R10 sticky", par_err, 1);
        bus_write(10'h003, 16'h0001);
        bus_read(10'h003, rd); chk("R10 cleared keeps slot", rd, 16'h0006);
        bus_write(10'h203, vec_of(3));
        @(negedge clk); irq_req = 8'h20;
        @(negedge clk);
        chk("R9 repaired vector", hw_vector, vec_of(3));
        bus_read(10'h003, rd); chk("R10 no new error", rd, 16'h0006);
        irq_req = '0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule